// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block is the interrupt and reset controller of a small 8-bit CPU core. It watches the non-maskable interrupt, the maskable interrupt and the overflow-set pins. At each instruction boundary that the core reports, it decides whether to start an entry sequence. An entry pushes the return address and the status byte onto the stack page, raises the interrupt-disable flag, and reads a two-byte vector into the program counter. After reset the same engine initialises the stack pointer and the status byte, then fetches the reset vector.

The core keeps its own PC, SP and P registers. It presents their values to this block and takes the loads this block drives. Memory is reached through a byte port that also carries the current execution bank. Read data must be valid in the same cycle as the address. While `busy_o` is high the core must not fetch, and the block ignores boundary strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held, and once after it is released, the block loads SP with 0xFF (stack byte 0x1FF). It loads P with T(bit5), B(bit4), I(bit2) and Z(bit1) set and D(bit3) taken from `p_i`, all other bits clear. It then reads the reset vector at 0xFFFC (low byte) and 0xFFFD (high byte) and loads PC with {high, low}. `busy_o` stays high until that PC load.
- R2: A non-maskable request is recorded only on a low-to-high change of `nmi_i`. Keeping the pin high causes no further entry. A high level already present when reset ends is not an edge.
- R3: When an IRQ request is pending and P bit2 (I) is clear at a boundary, the block enters through the vector at 0xFFFE/0xFFFF. Any cycle with `irq_i` high marks a request as pending.
- R4: At a boundary that attempts IRQ entry, the pending request is dropped whether or not it was taken. A request seen while I was set is therefore lost once `irq_i` has gone low.
- R5: At a boundary flagged with `cli_done_i`, no IRQ entry is made. The pending flag is reloaded from `irq_i`, so the interrupt is taken at the following boundary.
- R6: An entry writes three bytes in three consecutive cycles, at 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2. The bytes are the PC high byte, the PC low byte and P. SP is then loaded with its value minus 3.
- R7: The pushed copy of P has bit4 (B) cleared. In the cycle of that push, P is loaded with I (bit2) set and the other bits kept.
- R8: Vector bytes are read low first, then high, from page 0xFF. Every access carries `exec_bank_i` on `mem_bank_o`.
- R9: A high-to-low change of `sov_i` loads P with bit6 (V) set. A low-to-high change leaves P unchanged.
- R10: When a non-maskable request and an IRQ are both pending at one boundary, the non-maskable entry (vector 0xFFFA/0xFFFB) is taken.
- R11: `busy_o` rises in the cycle after the accepted boundary and stays high for exactly 5 cycles, through the PC load. Boundaries during that time start nothing. A non-maskable edge seen then is kept and served at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Non-maskable interrupt pin, active high |
| irq_i | input | 1 | Maskable interrupt pin, active high |
| sov_i | input | 1 | Overflow-set pin, acts on a falling change |
| boundary_i | input | 1 | Core is at an instruction boundary |
| cli_done_i | input | 1 | The finished instruction cleared I (with boundary_i) |
| exec_bank_i | input | BANK_W | Current execution bank |
| pc_i | input | 16 | Core PC value |
| sp_i | input | 8 | Core SP value (offset in page 1) |
| p_i | input | 8 | Core status byte |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 16 | Byte address |
| mem_bank_o | output | BANK_W | Bank tag of the access |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, same cycle |
| pc_ld_o | output | 1 | Load PC |
| pc_val_o | output | 16 | New PC |
| sp_ld_o | output | 1 | Load SP |
| sp_val_o | output | 8 | New SP |
| p_ld_o | output | 1 | Load P |
| p_val_o | output | 8 | New P |
| busy_o | output | 1 | Sequence running; the core holds off |

## Verification
The assertions check properties that hold every cycle. Stack writes stay in page 1 with an address falling by one per write, and vector reads stay in page 0xFF. A sequence opens with a push. The status push sets I and clears B. Every falling edge of the overflow pin loads V, and busy drops right after the PC load. Other behaviour needs an ordered history, so only the directed scenarios can show it. This covers the non-maskable edge rule under a held pin, the loss of a masked request, the one-boundary delay after an I-clearing instruction, the priority choice, and the exact vector values in different banks.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int         BANK_W     = 4,
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] VEC_PAGE   = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              irq_i,
  input  logic              sov_i,
  input  logic              boundary_i,
  input  logic              cli_done_i,
  input  logic [BANK_W-1:0] exec_bank_i,
  input  logic [15:0]       pc_i,
  input  logic [7:0]        sp_i,
  input  logic [7:0]        p_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [15:0]       mem_addr_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              pc_ld_o,
  output logic [15:0]       pc_val_o,
  output logic              sp_ld_o,
  output logic [7:0]        sp_val_o,
  output logic              p_ld_o,
  output logic [7:0]        p_val_o,
  output logic              busy_o
);
  localparam logic [7:0] VEC_NMI = 8'hFA;
  localparam logic [7:0] VEC_RST = 8'hFC;
  localparam logic [7:0] VEC_IRQ = 8'hFE;
  localparam logic [7:0] P_B = 8'h10, P_I = 8'h04, P_V = 8'h40, P_D = 8'h08;
  localparam logic [7:0] P_RESET = 8'h36;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_PH, S_PL, S_PP, S_VL, S_VH} st_t;

  st_t        st;
  logic       nmi_q, sov_q, nmi_pend, irq_pend;
  logic [7:0] sp_q, vec_q, lo_q;
  logic [15:0] pc_q;

  wire idle      = (st == S_IDLE);
  wire at_bnd    = idle && boundary_i;
  wire nmi_rise  = nmi_i && !nmi_q;
  wire sov_fall  = sov_q && !sov_i;
  wire take_nmi  = at_bnd && nmi_pend;
  wire irq_try   = at_bnd && !cli_done_i && !nmi_pend && irq_pend;
  wire take_irq  = irq_try && !p_i[2];

  always_ff @(posedge clk) sov_q <= sov_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RST;
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      irq_pend <= 1'b0;
      sp_q     <= '0;
      pc_q     <= '0;
      vec_q    <= VEC_RST;
      lo_q     <= '0;
    end else begin
      nmi_q    <= nmi_i;
      nmi_pend <= (nmi_pend && !take_nmi) || nmi_rise;
      if (at_bnd && cli_done_i)
        irq_pend <= irq_i;
      else if (irq_try)
        irq_pend <= 1'b0;
      else
        irq_pend <= irq_pend || irq_i;
      case (st)
        S_IDLE: if (take_nmi || take_irq) begin
          st    <= S_PH;
          sp_q  <= sp_i;
          pc_q  <= pc_i;
          vec_q <= take_nmi ? VEC_NMI : VEC_IRQ;
        end
        S_RST: st <= S_VL;
        S_PH:  begin st <= S_PL; sp_q <= sp_q - 8'd1; end
        S_PL:  begin st <= S_PP; sp_q <= sp_q - 8'd1; end
        S_PP:  begin st <= S_VL; sp_q <= sp_q - 8'd1; end
        S_VL:  begin st <= S_VH; lo_q <= mem_rdata_i; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = !idle;
  assign mem_we_o   = (st == S_PH) || (st == S_PL) || (st == S_PP);
  assign mem_req_o  = mem_we_o || (st == S_VL) || (st == S_VH);
  assign mem_addr_o = mem_we_o ? {STACK_PAGE, sp_q} : {VEC_PAGE, vec_q[7:1], st == S_VH};
  assign mem_bank_o = exec_bank_i;

  always_comb begin
    case (st)
      S_PH:    mem_wdata_o = pc_q[15:8];
      S_PL:    mem_wdata_o = pc_q[7:0];
      S_PP:    mem_wdata_o = p_i & ~P_B;
      default: mem_wdata_o = '0;
    endcase
  end

  assign sp_ld_o  = (st == S_PP) || (st == S_RST);
  assign sp_val_o = (st == S_RST) ? 8'hFF : sp_q - 8'd1;

  assign p_ld_o  = (st == S_PP) || (st == S_RST) || sov_fall;
  assign p_val_o = ((st == S_RST) ? ((p_i & P_D) | P_RESET) :
                    (st == S_PP)  ? (p_i | P_I) : p_i) | (sov_fall ? P_V : 8'h00);

  assign pc_ld_o  = (st == S_VH);
  assign pc_val_o = {mem_rdata_i, lo_q};
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sov_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [15:0] mem_addr_o,
  input logic [7:0]  mem_wdata_o,
  input logic        sp_ld_o,
  input logic        p_ld_o,
  input logic [7:0]  p_val_o,
  input logic        pc_ld_o,
  input logic        busy_o
);
  a_r6_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_addr_o[15:8] == 8'h01);

  a_r6_sp_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> mem_addr_o[7:0] == $past(mem_addr_o[7:0]) - 8'd1);

  a_r8_vec_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |-> mem_addr_o[15:8] == 8'hFF);

  a_r11_push_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_we_o);

  a_r11_pc_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_o |=> !busy_o);

  a_r7_status_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && sp_ld_o) |-> (p_ld_o && p_val_o[2] && !mem_wdata_o[4]));

  a_r9_v_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sov_i) |-> (p_ld_o && p_val_o[6]));
endmodule

bind irq_entry_seq irq_entry_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sov_i(sov_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .sp_ld_o(sp_ld_o), .p_ld_o(p_ld_o),
  .p_val_o(p_val_o), .pc_ld_o(pc_ld_o), .busy_o(busy_o)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 1'b0, irq = 1'b0, sov = 1'b0, bnd = 1'b0, cli = 1'b0;
  logic [3:0] bank = 4'hF;
  logic [15:0] pc_r = 16'h0000;
  logic [7:0]  sp_r = 8'h00, p_r = 8'h08;
  logic        mreq, mwe, pcld, spld, pld, busy;
  logic [15:0] maddr, pcval;
  logic [3:0]  mbank;
  logic [7:0]  mwd, mrd, spval, pval;

  logic        pre_en = 1'b0;
  logic [15:0] pre_pc = '0;
  logic [7:0]  pre_sp = '0, pre_p = '0;

  logic [15:0] wa [256];
  logic [7:0]  wd [256];
  logic [3:0]  wb [256];
  int wn = 0, bcnt = 0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rd(input logic [15:0] a, input logic [3:0] b);
    return a[7:0] ^ 8'h5A ^ {b, 4'h0};
  endfunction
  assign mrd = rd(maddr, mbank);

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_i(irq), .sov_i(sov),
    .boundary_i(bnd), .cli_done_i(cli), .exec_bank_i(bank),
    .pc_i(pc_r), .sp_i(sp_r), .p_i(p_r),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_bank_o(mbank),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd),
    .pc_ld_o(pcld), .pc_val_o(pcval), .sp_ld_o(spld), .sp_val_o(spval),
    .p_ld_o(pld), .p_val_o(pval), .busy_o(busy)
  );

  always @(posedge clk) begin
    if (pre_en) begin
      pc_r <= pre_pc; sp_r <= pre_sp; p_r <= pre_p;
    end else begin
      if (pcld) pc_r <= pcval;
      if (spld) sp_r <= spval;
      if (pld)  p_r  <= pval;
    end
    if (mwe && rst_n) begin
      wa[wn[7:0]] <= maddr; wd[wn[7:0]] <= mwd; wb[wn[7:0]] <= mbank;
      wn <= wn + 1;
    end
    if (busy && rst_n) bcnt <= bcnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic preset(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] p);
    pre_pc = pc; pre_sp = sp; pre_p = p; pre_en = 1'b1;
    cyc(1);
    pre_en = 1'b0;
  endtask

  task automatic pulse_bnd(input logic with_cli);
    bnd = 1'b1; cli = with_cli;
    cyc(1);
    bnd = 1'b0; cli = 1'b0;
  endtask

  task automatic chk_entry(input string req, input int base, input logic [7:0] sp0,
                           input logic [15:0] pc0, input logic [7:0] p0,
                           input logic [7:0] vlo, input logic [3:0] b);
    check({req, " count"}, wn - base, 3);
    check({req, " a0"}, wa[base[7:0]], {8'h01, sp0});
    check({req, " a1"}, wa[base[7:0]+1], {8'h01, sp0 - 8'd1});
    check({req, " a2"}, wa[base[7:0]+2], {8'h01, sp0 - 8'd2});
    check({req, " pch"}, wd[base[7:0]], pc0[15:8]);
    check({req, " pcl"}, wd[base[7:0]+1], pc0[7:0]);
    check({req, " R7 pushed P"}, wd[base[7:0]+2], p0 & 8'hEF);
    check({req, " bank"}, wb[base[7:0]+2], b);
    check({req, " R6 sp"}, sp_r, sp0 - 8'd3);
    check({req, " R7 P"}, p_r, p0 | 8'h04);
    check({req, " R8 pc"}, pc_r, {rd({8'hFF, vlo | 8'h01}, b), rd({8'hFF, vlo}, b)});
  endtask

  task automatic t_reset();
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 busy after release", busy, 1);
    cyc(4);
    check("R1 busy low", busy, 0);
    check("R1 sp", sp_r, 8'hFF);
    check("R1 p", p_r, 8'h3E);
    check("R1 pc", pc_r, {rd(16'hFFFD, 4'hF), rd(16'hFFFC, 4'hF)});
    check("R1 no writes", wn, 0);
  endtask

  task automatic t_nmi_edge();
    int base;
    preset(16'h1234, 8'hF0, 8'h30);
    bank = 4'h3;
    nmi = 1'b1; cyc(1);
    base = wn;
    pulse_bnd(1'b0);
    cyc(8);
    chk_entry("R2 nmi", base, 8'hF0, 16'h1234, 8'h30, 8'hFA, 4'h3);
    preset(16'h2000, 8'hE0, 8'h00);
    base = wn;
    pulse_bnd(1'b0);
    cyc(8);
    check("R2 held no retrigger", wn - base, 0);
    nmi = 1'b0;
    cyc(2);
  endtask

  task automatic t_irq_taken();
    int base, b0;
    preset(16'hABCD, 8'h80, 8'h81);
    bank = 4'h7;
    irq = 1'b1; cyc(1);
    base = wn; b0 = bcnt;
    pulse_bnd(1'b0);
    irq = 1'b0;
    cyc(8);
    chk_entry("R3 irq", base, 8'h80, 16'hABCD, 8'h81, 8'hFE, 4'h7);
    check("R11 busy length", bcnt - b0, 5);
  endtask

  task automatic t_irq_masked();
    int base;
    preset(16'h4000, 8'hC0, 8'h04);
    irq = 1'b1; cyc(1); irq = 1'b0;
    base = wn;
    pulse_bnd(1'b0);
    cyc(6);
    check("R4 masked no entry", wn - base, 0);
    preset(16'h4000, 8'hC0, 8'h00);
    pulse_bnd(1'b0);
    cyc(6);
    check("R4 request dropped", wn - base, 0);
    check("R4 pc unchanged", pc_r, 16'h4000);
  endtask

  task automatic t_cli_defer();
    int base;
    preset(16'h5566, 8'hA0, 8'h00);
    bank = 4'h1;
    irq = 1'b1; cyc(1);
    base = wn;
    pulse_bnd(1'b1);
    cyc(6);
    check("R5 no entry at cli boundary", wn - base, 0);
    pulse_bnd(1'b0);
    irq = 1'b0;
    cyc(8);
    chk_entry("R5 next boundary", base, 8'hA0, 16'h5566, 8'h00, 8'hFE, 4'h1);
  endtask

  task automatic t_priority();
    int base;
    preset(16'h0F0F, 8'h90, 8'h00);
    bank = 4'h9;
    irq = 1'b1; nmi = 1'b1; cyc(1);
    base = wn;
    pulse_bnd(1'b0);
    irq = 1'b0; nmi = 1'b0;
    cyc(8);
    chk_entry("R10 nmi first", base, 8'h90, 16'h0F0F, 8'h00, 8'hFA, 4'h9);
  endtask

  task automatic t_sov();
    preset(16'h0000, 8'h00, 8'h00);
    sov = 1'b1; cyc(2);
    check("R9 rise ignored", p_r, 8'h00);
    sov = 1'b0; cyc(2);
    check("R9 fall sets V", p_r, 8'h40);
  endtask

  task automatic t_busy_hold();
    int base;
    preset(16'h7777, 8'h70, 8'h00);
    bank = 4'h2;
    nmi = 1'b1; cyc(1);
    base = wn;
    pulse_bnd(1'b0);
    nmi = 1'b0; cyc(1);
    nmi = 1'b1;
    pulse_bnd(1'b0);
    cyc(8);
    check("R11 boundary ignored while busy", wn - base, 3);
    preset(16'h3333, 8'h60, 8'h00);
    base = wn;
    pulse_bnd(1'b0);
    cyc(8);
    chk_entry("R11 kept nmi", base, 8'h60, 16'h3333, 8'h00, 8'hFA, 4'h2);
    nmi = 1'b0;
  endtask

  initial begin
    t_reset();
    t_nmi_edge();
    t_irq_taken();
    t_irq_masked();
    t_cli_defer();
    t_priority();
    t_sov();
    t_busy_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule